// File: doc/BRIEF.md
# Post-Increment Bit-Reversing Address Unit

This unit forms memory addresses for two operands of an instruction. Each operand supplies a pointer register value, a post-increment flag and a bit-reverse flag. The unit returns two things per operand: the effective address used for the access, and the value to write back into the pointer register.

Two settings are held in configuration registers and shared by both operands: the increment step, and the count of low address bits to reverse. With the reverse flag set, the low bits of the pointer are mirrored to form the address. The mirrored value is never written back. With the post-increment flag set, the write-back value is the unmirrored pointer plus the step, wrapping at the address width. Together these let a program walk a transform buffer in bit-reversed order while its pointer counts up linearly.

The address and write-back paths are purely combinational. Only the two settings are registered, and a new setting takes effect on the clock edge that loads it.

Top module: `agu_brev_top`

## Requirements
- R1: After reset the increment step is 1 and the reverse count is 0. Under these settings the write-back is the pointer plus 1 when post-increment is set, and the address equals the pointer even when the reverse flag is set.
- R2: With the post-increment flag clear, an operand's write-back value equals its pointer value.
- R3: With the post-increment flag set, the write-back value is (pointer + step) mod 2^16.
- R4: A write on the step configuration port loads the step at the next rising clock edge. The new step is used from that edge onward.
- R5: With the reverse flag clear, the address equals the pointer value.
- R6: With the reverse flag set and a reverse count N of 2 or more, address bit i equals pointer bit N-1-i for every i below N.
- R7: With the reverse flag set, the address bits at positions N and above equal the same pointer bits.
- R8: A reverse count of 0 or 1 leaves the address equal to the pointer.
- R9: A write on the reverse-count port loads the count at the next rising edge. A written value above 16 is stored as 16.
- R10: The write-back value is computed from the unmirrored pointer. The reverse flag has no effect on it.
- R11: The two operands share the settings but use their own flags. For example, pointers 1 and 3 with N=4, step 1, reverse on both and post-increment on the second only give addresses 8 and 12 and write-back values 1 and 4.
- R12: Writes to the step and to the reverse count in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_wr_en | input | 1 | Load the increment step |
| step_wr_data | input | 16 | New increment step |
| rev_wr_en | input | 1 | Load the reverse count |
| rev_wr_data | input | 5 | New reverse count (values above 16 are clamped to 16) |
| op_val | input | 32 | Pointer values; operand k occupies bits [16k+15:16k] |
| op_inc | input | 2 | Post-increment flag per operand |
| op_rev | input | 2 | Bit-reverse flag per operand |
| mem_addr | output | 32 | Effective address per operand, packed like op_val |
| reg_wb | output | 32 | Write-back value per operand, packed like op_val |

## Verification
The assertions assume that the flags and pointer values are stable whenever the clock rises. They also assume that the configuration ports are driven to known values once reset is released. The bench changes every input only on the falling edge and keeps each enable high for exactly one cycle. It reads the outputs shortly after the inputs settle. Each write-back comparison made by the assertions uses either the step that was just loaded or two operands sampled in the same cycle, so no assertion depends on the reset-time step.

// File: rtl/brev_agu_pkg.sv
// Package: shared widths and helpers for the bit-reversing address unit.
// Assumes addresses are at most 32 bits wide.
package brev_agu_pkg;
    localparam int DEF_ADDR_W  = 16;
    localparam int DEF_NUM_OPS = 2;

    // Limit a requested reverse count to the address width.
    function automatic int clamp_count(input int raw, input int limit);
        return (raw > limit) ? limit : raw;
    endfunction
endpackage

// File: rtl/agu_cfg_regs.sv
// Module: holds the increment step and the reverse count.
// Assumes the write data ports are valid whenever their enables are high.
module agu_cfg_regs #(
    parameter int ADDR_W = brev_agu_pkg::DEF_ADDR_W,
    localparam int CNT_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_wr_en,
    input  logic [ADDR_W-1:0] step_wr_data,
    input  logic              rev_wr_en,
    input  logic [CNT_W-1:0]  rev_wr_data,
    output logic [ADDR_W-1:0] step_q,
    output logic [CNT_W-1:0]  nbits_q
);
    // Step register: reset to 1, loaded on its enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= ADDR_W'(1);
        else if (step_wr_en)
            step_q <= step_wr_data;
    end

    // Reverse-count register: reset to 0, loaded clamped to ADDR_W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nbits_q <= '0;
        else if (rev_wr_en)
            nbits_q <= CNT_W'(brev_agu_pkg::clamp_count(int'(rev_wr_data), ADDR_W));
    end
endmodule

// File: rtl/agu_bitrev.sv
// Module: mirrors the low nbits bits of din; the upper bits pass through.
// Assumes nbits never exceeds AW (the config registers guarantee this).
module agu_bitrev #(
    parameter int AW = brev_agu_pkg::DEF_ADDR_W,
    localparam int CW = $clog2(AW + 1)
) (
    input  logic [AW-1:0] din,
    input  logic [CW-1:0] nbits,
    output logic [AW-1:0] dout
);
    // Per-bit select between the mirrored source and the straight source.
    always_comb begin
        dout = din;
        for (int i = 0; i < AW; i++) begin
            if (i < int'(nbits))
                dout[i] = din[(int'(nbits) - 1 - i) % AW];
        end
    end
endmodule

// File: rtl/agu_lane.sv
// Module: one operand lane, producing the address and the write-back value.
// Assumes the step and count come from agu_cfg_regs.
module agu_lane #(
    parameter int ADDR_W = brev_agu_pkg::DEF_ADDR_W,
    localparam int CNT_W = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic              inc,
    input  logic              rev,
    input  logic [ADDR_W-1:0] step,
    input  logic [CNT_W-1:0]  nbits,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] wb
);
    logic [ADDR_W-1:0] mirrored;

    agu_bitrev #(.AW(ADDR_W)) u_rev (
        .din   (ptr),
        .nbits (nbits),
        .dout  (mirrored)
    );

    // Address select: mirrored only when the reverse flag is set.
    always_comb addr = rev ? mirrored : ptr;

    // Write-back: the unmirrored pointer, plus the step when incrementing.
    always_comb wb = inc ? (ptr + step) : ptr;
endmodule

// File: rtl/agu_brev_top.sv
// Module: a two-operand address unit with post-increment and partial bit reversal.
// Operand k uses slice [k*ADDR_W +: ADDR_W] of every packed vector.
// Both lanes share the step and the reverse count.
module agu_brev_top #(
    parameter int ADDR_W  = brev_agu_pkg::DEF_ADDR_W,
    parameter int NUM_OPS = brev_agu_pkg::DEF_NUM_OPS,
    localparam int CNT_W  = $clog2(ADDR_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_wr_en,
    input  logic [ADDR_W-1:0]         step_wr_data,
    input  logic                      rev_wr_en,
    input  logic [CNT_W-1:0]          rev_wr_data,
    input  logic [NUM_OPS*ADDR_W-1:0] op_val,
    input  logic [NUM_OPS-1:0]        op_inc,
    input  logic [NUM_OPS-1:0]        op_rev,
    output logic [NUM_OPS*ADDR_W-1:0] mem_addr,
    output logic [NUM_OPS*ADDR_W-1:0] reg_wb
);
    logic [ADDR_W-1:0] step_q;
    logic [CNT_W-1:0]  nbits_q;

    agu_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_wr_en   (step_wr_en),
        .step_wr_data (step_wr_data),
        .rev_wr_en    (rev_wr_en),
        .rev_wr_data  (rev_wr_data),
        .step_q       (step_q),
        .nbits_q      (nbits_q)
    );

    // One lane per operand.
    for (genvar k = 0; k < NUM_OPS; k++) begin : g_lane
        agu_lane #(.ADDR_W(ADDR_W)) u_lane (
            .ptr   (op_val[k*ADDR_W +: ADDR_W]),
            .inc   (op_inc[k]),
            .rev   (op_rev[k]),
            .step  (step_q),
            .nbits (nbits_q),
            .addr  (mem_addr[k*ADDR_W +: ADDR_W]),
            .wb    (reg_wb[k*ADDR_W +: ADDR_W])
        );
    end
endmodule

// File: rtl/agu_brev_chk.sv
// Checker: properties on the ports of agu_brev_top, attached with bind.
// Assumes the inputs are stable at each rising edge.
module agu_brev_chk #(
    parameter int ADDR_W  = brev_agu_pkg::DEF_ADDR_W,
    parameter int NUM_OPS = brev_agu_pkg::DEF_NUM_OPS,
    localparam int CNT_W  = $clog2(ADDR_W + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      step_wr_en,
    input logic [ADDR_W-1:0]         step_wr_data,
    input logic [NUM_OPS*ADDR_W-1:0] op_val,
    input logic [NUM_OPS-1:0]        op_inc,
    input logic [NUM_OPS-1:0]        op_rev,
    input logic [NUM_OPS*ADDR_W-1:0] mem_addr,
    input logic [NUM_OPS*ADDR_W-1:0] reg_wb
);
    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        // R2
        no_inc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !op_inc[k] |-> reg_wb[k*ADDR_W +: ADDR_W] == op_val[k*ADDR_W +: ADDR_W]);
        // R5
        no_rev_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !op_rev[k] |-> mem_addr[k*ADDR_W +: ADDR_W] == op_val[k*ADDR_W +: ADDR_W]);
        // R6
        rev_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
            op_rev[k] |-> $countones(mem_addr[k*ADDR_W +: ADDR_W]) ==
                          $countones(op_val[k*ADDR_W +: ADDR_W]));
        // R4
        step_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            step_wr_en |=> (op_inc[k] -> reg_wb[k*ADDR_W +: ADDR_W] ==
                            ADDR_W'(op_val[k*ADDR_W +: ADDR_W] + $past(step_wr_data))));
    end

    if (NUM_OPS > 1) begin : g_pair
        // R11
        shared_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_inc[0] && op_inc[1]) |->
            ADDR_W'(reg_wb[0 +: ADDR_W] - op_val[0 +: ADDR_W]) ==
            ADDR_W'(reg_wb[ADDR_W +: ADDR_W] - op_val[ADDR_W +: ADDR_W]));
    end
endmodule

bind agu_brev_top agu_brev_chk #(.ADDR_W(ADDR_W), .NUM_OPS(NUM_OPS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_wr_en   (step_wr_en),
    .step_wr_data (step_wr_data),
    .op_val       (op_val),
    .op_inc       (op_inc),
    .op_rev       (op_rev),
    .mem_addr     (mem_addr),
    .reg_wb       (reg_wb)
);

// File: tb/agu_brev_top_tb.sv
// Bench: directed scenarios, one task each, with their own checks.
module agu_brev_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_wr_en = 1'b0;
    logic [AW-1:0] step_wr_data = '0;
    logic          rev_wr_en = 1'b0;
    logic [4:0]    rev_wr_data = '0;
    logic [2*AW-1:0] op_val = '0;
    logic [1:0]    op_inc = '0;
    logic [1:0]    op_rev = '0;
    logic [2*AW-1:0] mem_addr;
    logic [2*AW-1:0] reg_wb;

    int checks = 0;
    int failures = 0;

    agu_brev_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .step_wr_en(step_wr_en), .step_wr_data(step_wr_data),
        .rev_wr_en(rev_wr_en), .rev_wr_data(rev_wr_data),
        .op_val(op_val), .op_inc(op_inc), .op_rev(op_rev),
        .mem_addr(mem_addr), .reg_wb(reg_wb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected address: the low n bits mirrored, the rest kept.
    function automatic logic [AW-1:0] exp_rev(input logic [AW-1:0] v, input int n);
        logic [AW-1:0] r = v;
        for (int i = 0; i < n; i++) r[i] = v[n-1-i];
        return r;
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive both operands at the falling edge, then let the outputs settle.
    task automatic apply(input logic [AW-1:0] v0, input logic [AW-1:0] v1,
                         input logic [1:0] inc, input logic [1:0] rev);
        @(negedge clk);
        op_val = {v1, v0}; op_inc = inc; op_rev = rev;
        #1;
    endtask

    // Load the settings; the new values are in force after the next rising edge.
    task automatic cfg(input logic we_s, input logic [AW-1:0] s, input logic we_n, input logic [4:0] n);
        @(negedge clk);
        step_wr_en = we_s; step_wr_data = s; rev_wr_en = we_n; rev_wr_data = n;
        @(negedge clk);
        step_wr_en = 1'b0; rev_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        apply(16'h0005, 16'hABCD, 2'b01, 2'b10);
        check("R1 step", reg_wb[0 +: AW], 16'h0006);
        check("R1 count", mem_addr[AW +: AW], 16'hABCD);
    endtask

    task automatic t_example;
        cfg(1, 16'd1, 1, 5'd4);
        apply(16'd1, 16'd3, 2'b10, 2'b11);
        check("R11 addr0", mem_addr[0 +: AW], 16'd8);
        check("R11 addr1", mem_addr[AW +: AW], 16'd12);
        check("R11 wb0", reg_wb[0 +: AW], 16'd1);
        check("R11 wb1", reg_wb[AW +: AW], 16'd4);
    endtask

    task automatic t_noinc;
        apply(16'h1234, 16'hFFFF, 2'b00, 2'b00);
        check("R2 wb0", reg_wb[0 +: AW], 16'h1234);
        check("R2 wb1", reg_wb[AW +: AW], 16'hFFFF);
        check("R5 addr0", mem_addr[0 +: AW], 16'h1234);
    endtask

    task automatic t_step;
        cfg(1, 16'd7, 0, 5'd0);
        apply(16'h0100, 16'h0000, 2'b01, 2'b00);
        check("R4 step7", reg_wb[0 +: AW], 16'h0107);
        cfg(1, 16'd3, 0, 5'd0);
        apply(16'hFFFE, 16'h0000, 2'b01, 2'b00);
        check("R3 wrap", reg_wb[0 +: AW], 16'h0001);
    endtask

    task automatic t_upper;
        cfg(0, 16'd0, 1, 5'd4);
        apply(16'hA5F1, 16'h0000, 2'b00, 2'b01);
        check("R7 upper", mem_addr[0 +: AW], 16'hA5F8);
        cfg(0, 16'd0, 1, 5'd8);
        apply(16'h3C01, 16'h0000, 2'b00, 2'b01);
        check("R6 n8", mem_addr[0 +: AW], exp_rev(16'h3C01, 8));
    endtask

    task automatic t_small_n;
        cfg(0, 16'd0, 1, 5'd1);
        apply(16'h00F3, 16'h0000, 2'b00, 2'b01);
        check("R8 n1", mem_addr[0 +: AW], 16'h00F3);
        cfg(0, 16'd0, 1, 5'd0);
        apply(16'h00F3, 16'h0000, 2'b00, 2'b01);
        check("R8 n0", mem_addr[0 +: AW], 16'h00F3);
    endtask

    task automatic t_clamp;
        cfg(0, 16'd0, 1, 5'd31);
        apply(16'h0001, 16'h1234, 2'b00, 2'b11);
        check("R9 clamp", mem_addr[0 +: AW], 16'h8000);
        check("R9 clamp1", mem_addr[AW +: AW], exp_rev(16'h1234, 16));
    endtask

    task automatic t_wb_unrev;
        cfg(1, 16'd2, 1, 5'd4);
        apply(16'h0001, 16'h0001, 2'b11, 2'b01);
        check("R10 rev", reg_wb[0 +: AW], 16'h0003);
        check("R10 norev", reg_wb[AW +: AW], 16'h0003);
    endtask

    task automatic t_both_cfg;
        cfg(1, 16'd16, 1, 5'd2);
        apply(16'h0002, 16'h0010, 2'b10, 2'b01);
        check("R12 count", mem_addr[0 +: AW], 16'h0001);
        check("R12 step", reg_wb[AW +: AW], 16'h0020);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_noinc();
        t_step();
        t_upper();
        t_small_n();
        t_clamp();
        t_wb_unrev();
        t_both_cfg();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule